// File: doc/BRIEF.md
# Two-Wire Register Target with Command-Coded Block Access

This block is a target on a two-wire serial bus (I2C-compatible, 7-bit addressing) that holds a small byte-wide register file. SCL and SDA come in as plain logic levels and are oversampled by the system clock. SDA is driven back through an open-drain enable: when `sda_oe` is high, the pad pulls the line low.

A write transaction carries the address byte, then a command byte, then data. In the command byte, bit 7 picks the mode: 1 means one byte and 0 means a block. Bits 6:0 give the register offset where the access starts. A read transaction uses the offset and mode set by the last command byte. A repeated START therefore allows "set offset, then read" within one bus transaction.

The length of a block read is not set by the master. It comes from a count field held in the register file. Offset 00h holds a fixed identification byte. Two low bits of the target address live in a register, so several copies can share one bus. Every register write and every register fetch is also reported on a strobe port to the rest of the chip.

Top module: `twreg_slave`

FSM states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_CMD` and `ST_CMD_ACK`: receiving and acknowledging the command byte.
- `ST_WDATA` and `ST_WDATA_ACK`: receiving a data byte, then ACK or NACK.
- `ST_RDATA`: shifting a byte out.
- `ST_RDATA_ACK`: sampling the master's acknowledge.
- `ST_SKIP`: silent until the next START.

Transitions:
- Any START leads to `ST_ADDR`, and any STOP leads to `ST_IDLE`.
- A completed address byte leads to `ST_ADDR_ACK` on a match, and to `ST_SKIP` otherwise.
- The end of an address ACK leads to `ST_CMD` for a write. For a read it leads to `ST_RDATA` if bytes remain, and to `ST_SKIP` if none remain.
- A completed command byte leads to `ST_CMD_ACK`, and then to `ST_WDATA`.
- A completed data byte leads to `ST_WDATA_ACK`, and then back to `ST_WDATA`.
- The eighth bit sent leads to `ST_RDATA_ACK`. From there the block goes back to `ST_RDATA` when the master ACKs and bytes remain, and to `ST_SKIP` otherwise.

## Requirements
- R1: The target answers with an ACK to the 7-bit address whose upper five bits are 11001 and whose two low bits equal register 01h bits [1:0]; the address byte's LSB is 1 for read and 0 for write (reset address 64h, write byte C8h, read byte C9h).
- R2: For any other address the target gives no ACK and leaves SDA released for the rest of the transaction until a START is seen.
- R3: The command byte (first byte after a write address) is always ACKed; its bit 7 = 1 selects single-byte access, bit 7 = 0 selects block access, and bits 6:0 load the starting offset.
- R4: In block mode each written data byte is ACKed and stored at the current offset, which then increases by one; each byte is reported on the write strobe as soon as its eighth bit is received.
- R5: In single-byte mode only the first data byte after the command is stored and ACKed; later data bytes in the same transaction are NACKed and not stored.
- R6: A block read sends exactly N bytes from the starting offset upward, where N is register 06h bits [7:1], each MSB first. After the Nth byte, SDA stays released even if the master ACKs. SDA only changes while SCL is low.
- R7: While `wr_refuse` is high, data bytes are NACKed and no register changes; reads still return data.
- R8: Offset 00h reads the identification byte (parameter, default A5h); a write to it is ACKed but discarded.
- R9: A repeated START returns to the address phase, so a command byte can be followed by a read in the same transaction.
- R10: After a STOP the target is idle and SDA is released.
- R11: After reset SDA is released, no strobe is active, register 01h is 00h and register 06h is 60h (count 30h); other registers are 00h.
- R12: Offsets at or above the register count `DEPTH` (default 48) read as 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| wr_refuse | input | 1 | When high, incoming write data is refused |
| sda_oe | output | 1 | High pulls SDA low |
| reg_we | output | 1 | One-cycle pulse: a register was written |
| reg_waddr | output | 7 | Offset of the register written |
| reg_wdata | output | 8 | Value written |
| reg_re | output | 1 | One-cycle pulse: a register was fetched for reading |
| reg_raddr | output | 7 | Offset of the register fetched |

## Verification
The bench drives the following corner cases:
- A block read that reaches its count while the master keeps ACKing. A design that ignored the count would keep driving bytes, and would read back something other than FFh.
- A second data byte in single-byte mode. A design that treated it as a block would ACK it and overwrite the next register.
- Writes under `wr_refuse`, to offset 00h, and past the end of the register file. An error in any of these shows up as a changed readback or a stray write strobe.
- A change of the address low bits. The new address must be ACKed and the old one ignored. A design that kept the address fixed would fail both checks.

// File: rtl/twreg_pkg.sv
package twreg_pkg;

    localparam int OFS_W = 7;
    localparam logic [4:0] TW_ADDR_HI = 5'b11001;
    localparam int ADDR_LO_REG = 1;
    localparam int BCOUNT_REG = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } tw_state_e;

endpackage

// File: rtl/twreg_line_sense.sv
module twreg_line_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        logic scl_r;
        logic sda_r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_in;
                    sda_r <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= g_sync[i-1].scl_r;
                    sda_r <= g_sync[i-1].sda_r;
                end
            end
        end
    end

    logic scl_p;
    logic sda_p;

    assign scl_q = g_sync[STAGES-1].scl_r;
    assign sda_q = g_sync[STAGES-1].sda_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_det = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/twreg_regbank.sv
module twreg_regbank
    import twreg_pkg::*;
#(
    parameter int          DEPTH      = 48,
    parameter logic [7:0]  ID_BYTE    = 8'hA5,
    parameter logic [6:0]  BCOUNT_RST = 7'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFS_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [OFS_W-1:0] raddr,
    output logic [7:0]       rdata,
    output logic [1:0]       addr_lo,
    output logic [6:0]       bcount
);

    localparam logic [OFS_W:0] DEPTH_W = (OFS_W+1)'(DEPTH);

    logic [7:0] mem [1:DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i < DEPTH; i++) begin
                mem[i] <= (i == BCOUNT_REG) ? {BCOUNT_RST, 1'b0} : 8'h00;
            end
        end else if (we && (waddr != '0) && ({1'b0, waddr} < DEPTH_W)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        if (raddr == '0) begin
            rdata = ID_BYTE;
        end else if ({1'b0, raddr} < DEPTH_W) begin
            rdata = mem[raddr];
        end else begin
            rdata = 8'h00;
        end
    end

    assign addr_lo = mem[ADDR_LO_REG][1:0];
    assign bcount  = mem[BCOUNT_REG][7:1];

endmodule

// File: rtl/twreg_slave.sv
module twreg_slave
    import twreg_pkg::*;
#(
    parameter int          DEPTH       = 48,
    parameter logic [7:0]  ID_BYTE     = 8'hA5,
    parameter logic [6:0]  BCOUNT_RST  = 7'h30,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             wr_refuse,
    output logic             sda_oe,
    output logic             reg_we,
    output logic [OFS_W-1:0] reg_waddr,
    output logic [7:0]       reg_wdata,
    output logic             reg_re,
    output logic [OFS_W-1:0] reg_raddr
);

    localparam logic [OFS_W:0] DEPTH_W = (OFS_W+1)'(DEPTH);

    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

    twreg_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_state_e        state, state_n;
    logic [3:0]       bit_cnt;
    logic [7:0]       sh;
    logic             rw_q, single_q, wr_used, ack_q, mack_q;
    logic [OFS_W-1:0] ptr;
    logic [6:0]       remain;
    logic [7:0]       rdata;
    logic [1:0]       addr_lo;
    logic [6:0]       bcount;

    twreg_regbank #(
        .DEPTH      (DEPTH),
        .ID_BYTE    (ID_BYTE),
        .BCOUNT_RST (BCOUNT_RST)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .raddr   (ptr),
        .rdata   (rdata),
        .addr_lo (addr_lo),
        .bcount  (bcount)
    );

    logic byte_done, addr_match, wr_ok, more_rd;
    assign byte_done  = scl_fall && (bit_cnt == 4'd8);
    assign addr_match = (sh[7:1] == {TW_ADDR_HI, addr_lo});
    assign wr_ok      = !wr_refuse && (!single_q || !wr_used);
    assign more_rd    = (remain != 7'd0);

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_n = ST_IDLE;
                ST_ADDR:      if (byte_done) state_n = addr_match ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) state_n = rw_q ? (more_rd ? ST_RDATA : ST_SKIP) : ST_CMD;
                ST_CMD:       if (byte_done) state_n = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:     if (byte_done) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_n = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) state_n = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_n = (!mack_q && more_rd) ? ST_RDATA : ST_SKIP;
                ST_SKIP:      state_n = ST_SKIP;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            sh        <= '0;
            rw_q      <= 1'b0;
            single_q  <= 1'b0;
            wr_used   <= 1'b0;
            ack_q     <= 1'b0;
            mack_q    <= 1'b1;
            ptr       <= '0;
            remain    <= '0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
            reg_re    <= 1'b0;
            reg_raddr <= '0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                sh      <= '0;
                ack_q   <= 1'b0;
            end else if (stop_det) begin
                ack_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            sh      <= {sh[6:0], sda_q};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_match) begin
                                    ack_q  <= 1'b1;
                                    rw_q   <= sh[0];
                                    remain <= single_q ? 7'd1 : bcount;
                                end
                            end else if (state == ST_CMD) begin
                                ack_q    <= 1'b1;
                                single_q <= sh[7];
                                ptr      <= sh[6:0];
                                wr_used  <= 1'b0;
                            end else if (wr_ok) begin
                                ack_q   <= 1'b1;
                                wr_used <= 1'b1;
                                if (!single_q) ptr <= ptr + 7'd1;
                                if ((ptr != '0) && ({1'b0, ptr} < DEPTH_W)) begin
                                    reg_we    <= 1'b1;
                                    reg_waddr <= ptr;
                                    reg_wdata <= sh;
                                end
                            end else begin
                                ack_q <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK, ST_RDATA_ACK: begin
                        if (state == ST_RDATA_ACK && scl_rise) mack_q <= sda_q;
                        if (scl_fall) begin
                            ack_q   <= 1'b0;
                            bit_cnt <= '0;
                            if ((state == ST_ADDR_ACK && rw_q && more_rd) ||
                                (state == ST_RDATA_ACK && !mack_q && more_rd)) begin
                                sh        <= rdata;
                                reg_re    <= 1'b1;
                                reg_raddr <= ptr;
                                remain    <= remain - 7'd1;
                                if (!single_q) ptr <= ptr + 7'd1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                mack_q  <= 1'b1;
                            end else begin
                                sh      <= {sh[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        bit_cnt <= '0;
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = ack_q;
            ST_RDATA:                              sda_oe = ~sh[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    a_r10_released_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    a_r6_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q);

    a_r7_no_write_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !$past(wr_refuse));

    a_r8_id_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_waddr != '0));

    a_r12_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ({1'b0, reg_waddr} < DEPTH_W));

    a_r2_silent_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !start_det) |=> !sda_oe);

endmodule

// File: tb/twreg_slave_bench.sv
module twreg_slave_bench;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_refuse = 1'b0;
    logic sda_oe, reg_we, reg_re;
    logic [6:0] reg_waddr, reg_raddr;
    logic [7:0] reg_wdata;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int we_count = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    twreg_slave u_twreg_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .wr_refuse (wr_refuse),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_re    (reg_re),
        .reg_raddr (reg_raddr)
    );

    always @(posedge clk) if (reg_we) we_count <= we_count + 1;

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(Q);
            scl_m = 1'b1; wait_q(Q);
            scl_m = 1'b0; wait_q(Q);
        end
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q / 2);
        acked = !sda_bus;
        wait_q(Q / 2);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wait_q(Q);
            scl_m = 1'b1; wait_q(Q / 2);
            b = {b[6:0], sda_bus};
            wait_q(Q / 2);
            scl_m = 1'b0;
        end
        wait_q(Q / 2);
        sda_m = !master_ack; wait_q(Q / 2);
        scl_m = 1'b1; wait_q(Q);
        scl_m = 1'b0; wait_q(Q / 2);
        sda_m = 1'b1; wait_q(Q / 2);
    endtask

    // write: address byte, command, then data bytes; returns ACK of each data byte
    task automatic write_seq(input logic [7:0] abyte, input logic [7:0] cmd,
                             input logic [7:0] d [], output bit acks []);
        bit a;
        acks = new[d.size()];
        bus_start();
        send_byte(abyte, a);
        send_byte(cmd, a);
        foreach (d[i]) begin
            send_byte(d[i], a);
            acks[i] = a;
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] cmd, input int n, input bit ack_last,
                            output logic [7:0] r []);
        bit a;
        r = new[n];
        bus_start();
        send_byte(8'hC8, a);
        send_byte(cmd, a);
        bus_start();
        send_byte(8'hC9, a);
        for (int i = 0; i < n; i++) recv_byte((i < n - 1) || ack_last, r[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        check(reg_we == 1'b0 && reg_re == 1'b0, "R11 strobes idle", reg_we, 0);
    endtask

    task automatic t_reset_regs();
        logic [7:0] r [];
        read_seq(8'h86, 1, 1'b0, r);
        check(r[0] == 8'h60, "R11 count register", r[0], 8'h60);
        read_seq(8'h81, 1, 1'b0, r);
        check(r[0] == 8'h00, "R11 address register", r[0], 8'h00);
    endtask

    task automatic t_address();
        bit a, b;
        bus_start();
        send_byte(8'hC8, a);
        bus_stop();
        check(a, "R1 own address ACK", a, 1);
        check(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
        bus_start();
        send_byte(8'hCA, a);
        send_byte(8'h00, b);
        bus_stop();
        check(!a, "R2 foreign address NACK", a, 0);
        check(!b, "R2 silent after mismatch", b, 0);
    endtask

    task automatic t_block();
        logic [7:0] d [];
        bit acks [];
        logic [7:0] r [];
        int w0;
        d = '{8'h06};
        write_seq(8'hC8, 8'h86, d, acks);
        w0 = we_count;
        d = '{8'hA1, 8'hB2, 8'hC3};
        write_seq(8'hC8, 8'h10, d, acks);
        check(acks[0] && acks[1] && acks[2], "R4 block bytes ACKed", acks[2], 1);
        check(we_count - w0 == 3, "R4 three write strobes", we_count - w0, 3);
        read_seq(8'h10, 4, 1'b1, r);
        check(r[0] == 8'hA1, "R6 R9 block byte 0", r[0], 8'hA1);
        check(r[1] == 8'hB2, "R6 block byte 1", r[1], 8'hB2);
        check(r[2] == 8'hC3, "R6 block byte 2", r[2], 8'hC3);
        check(r[3] == 8'hFF, "R6 released after count", r[3], 8'hFF);
    endtask

    task automatic t_single();
        logic [7:0] d [];
        bit acks [];
        logic [7:0] r [];
        d = '{8'h5A, 8'h77};
        write_seq(8'hC8, 8'hA0, d, acks);
        check(acks[0], "R5 first byte ACK", acks[0], 1);
        check(!acks[1], "R5 second byte NACK", acks[1], 0);
        read_seq(8'hA0, 1, 1'b0, r);
        check(r[0] == 8'h5A, "R3 R5 single read", r[0], 8'h5A);
        read_seq(8'hA1, 1, 1'b0, r);
        check(r[0] == 8'h00, "R5 neighbour untouched", r[0], 8'h00);
        read_seq(8'h91, 1, 1'b0, r);
        check(r[0] == 8'hB2, "R3 single offset", r[0], 8'hB2);
    endtask

    task automatic t_refuse();
        logic [7:0] d [];
        bit acks [];
        logic [7:0] r [];
        int w0;
        wr_refuse = 1'b1;
        w0 = we_count;
        d = '{8'h00};
        write_seq(8'hC8, 8'h10, d, acks);
        check(!acks[0], "R7 refused byte NACK", acks[0], 0);
        check(we_count == w0, "R7 no write strobe", we_count - w0, 0);
        read_seq(8'h90, 1, 1'b0, r);
        check(r[0] == 8'hA1, "R7 read while refused", r[0], 8'hA1);
        wr_refuse = 1'b0;
    endtask

    task automatic t_id_and_range();
        logic [7:0] d [];
        bit acks [];
        logic [7:0] r [];
        int w0;
        w0 = we_count;
        d = '{8'h33};
        write_seq(8'hC8, 8'h80, d, acks);
        check(acks[0], "R8 id write ACKed", acks[0], 1);
        check(we_count == w0, "R8 id write discarded", we_count - w0, 0);
        read_seq(8'h80, 1, 1'b0, r);
        check(r[0] == 8'hA5, "R8 id value", r[0], 8'hA5);
        d = '{8'h44};
        write_seq(8'hC8, 8'hB0, d, acks);
        read_seq(8'hB0, 1, 1'b0, r);
        check(r[0] == 8'h00, "R12 beyond depth reads zero", r[0], 8'h00);
    endtask

    task automatic t_addr_change();
        logic [7:0] d [];
        bit acks [];
        bit a;
        d = '{8'h02};
        write_seq(8'hC8, 8'h81, d, acks);
        bus_start(); send_byte(8'hCC, a); bus_stop();
        check(a, "R1 new address ACK", a, 1);
        bus_start(); send_byte(8'hC8, a); bus_stop();
        check(!a, "R1 old address NACK", a, 0);
    endtask

    initial begin
        wait_q(5);
        t_reset();
        rst_n = 1'b1;
        wait_q(5);
        t_reset_regs();
        t_address();
        t_block();
        t_single();
        t_refuse();
        t_id_and_range();
        t_addr_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule